// File: doc/BRIEF.md
# Serial Register Access Master

This block sits on the host side of a serial register link and turns one command into a complete framed transaction. A command carries a direction flag, a 10-bit register address, a byte count and up to eight bytes of write data. The block lowers the select line, sends a 16-bit header followed by a data phase of one to eight bytes, raises the select line again and then reports completion with a single-cycle pulse. For reads it collects the returned bytes and presents them together with that pulse.

The serial clock is derived from the system clock by a programmable half-period divider. The clock idles low. Outgoing bits change on rising serial clock edges, and read bits are captured on falling edges. Two link variants are supported. In the 4-wire variant read data returns on a separate input. In the 3-wire variant the master releases the shared line after the header of a read so that the far end can drive it. A bit-order input chooses between most-significant-first and least-significant-first framing.

Top module: `spi_xact_master`

## Requirements
- R1: The header is 16 bits: bit 15 is the direction (1 = write, 0 = read), bits 14:12 hold the byte count minus one, bits 11:10 are zero and bits 9:0 are the address. In most-significant-first mode bit 15 is sent first.
- R2: spi_sclk is low whenever spi_cs_n is high. spi_cs_n falls one half period before the first rising serial clock edge and rises one half period after the last falling edge.
- R3: spi_sdo changes only on rising serial clock edges. Read data is captured on falling serial clock edges.
- R4: A transaction has exactly 16 + 8·N serial clock pulses, where N = cmd_len_m1 + 1. The data bytes follow the header in order, starting with cmd_wdata[7:0].
- R5: Each serial clock half period lasts max(cfg_half_div, 2) system clock cycles. This value is sampled when the command is accepted.
- R6: For a read, byte k received in the data phase appears at rsp_rdata[8k+7:8k]. Bytes beyond N read as zero.
- R7: spi_sdo_oe is low while spi_cs_n is high. During a 3-wire read it is low from the first data-phase rising edge until the end of the transaction. In all other cases it is high while spi_cs_n is low.
- R8: With cfg_lsb_first set, the header is sent bit 0 first and each data byte is sent and received bit 0 first.
- R9: busy is high from acceptance until completion, and cmd_valid has no effect while busy is high. done is a one-cycle pulse that is asserted in the cycle spi_cs_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a transaction (accepted when not busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 10 | Register address |
| cmd_len_m1 | input | 3 | Byte count minus one |
| cmd_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| cfg_lsb_first | input | 1 | Least-significant-bit-first framing |
| cfg_three_wire | input | 1 | Read data on the shared line |
| cfg_half_div | input | DIV_W | Serial clock half period in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read bytes, byte 0 in bits 7:0 |
| spi_cs_n | output | 1 | Active-low select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data out / shared line drive value |
| spi_sdo_oe | output | 1 | Drive enable for the data output |
| spi_sdi | input | 1 | Read data in 4-wire mode |
| spi_sdio_i | input | 1 | Shared line value in 3-wire mode |

## Verification
The bench builds the block with its default parameters: an 8-bit divider field and a two-cycle minimum half period. It drives half-period settings from 0 to 4, so both the clamp to two cycles and the unclamped divider are reached. A timing monitor measures every serial clock edge, including the lead-in and the trail. Random commands cover all eight byte counts, both directions, both bit orders and both link variants, so the header count field, the masking of unused read bytes and the 3-wire line release are all exercised.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
   localparam int CTRL_W  = 16;
   localparam int ADDR_W  = 10;
   localparam int LEN_W   = 3;
   localparam int BYTES   = 1 << LEN_W;
   localparam int DATA_W  = 8 * BYTES;
   localparam int IMG_W   = CTRL_W + DATA_W;
   localparam int IDX_W   = $clog2(IMG_W);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL
   } xact_st_e;

   function automatic logic [CTRL_W-1:0] make_header(
      input logic              wr,
      input logic [LEN_W-1:0]  len_m1,
      input logic [ADDR_W-1:0] addr);
      return {wr, len_m1, 2'b00, addr};
   endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] half_q;

   assign tick = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         half_q <= '0;
      end else if (start) begin
         half_q <= half;
         cnt    <= half - 1'b1;
      end else if (tick) begin
         cnt    <= half_q - 1'b1;
      end else if (run) begin
         cnt    <= cnt - 1'b1;
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R5
endmodule

// File: rtl/spi_frame_map.sv
module spi_frame_map
   import spi_xact_pkg::*;
(
   input  logic [CTRL_W-1:0] header,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lsb_first,
   output logic [IMG_W-1:0]  img
);
   for (genvar k = 0; k < CTRL_W; k++) begin : g_hdr
      assign img[k] = lsb_first ? header[k] : header[CTRL_W-1-k];
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign img[CTRL_W + 8*b + k] = lsb_first ? wdata[8*b + k] : wdata[8*b + 7 - k];
      end
   end
endmodule

// File: rtl/spi_xact_master.sv
module spi_xact_master
   import spi_xact_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [9:0]        cmd_addr,
   input  logic [2:0]        cmd_len_m1,
   input  logic [63:0]       cmd_wdata,
   input  logic              cfg_lsb_first,
   input  logic              cfg_three_wire,
   input  logic [DIV_W-1:0]  cfg_half_div,
   output logic              busy,
   output logic              done,
   output logic [63:0]       rsp_rdata,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   input  logic              spi_sdi,
   input  logic              spi_sdio_i
);
   if (MIN_HALF < 2) begin : g_bad_min
      $error("MIN_HALF must be at least 2");
   end
   if (DIV_W < 2 || (1 << DIV_W) <= MIN_HALF) begin : g_bad_div
      $error("DIV_W too narrow for MIN_HALF");
   end

   xact_st_e              st;
   logic                  wr_q, lsb_q, tw_q;
   logic [LEN_W-1:0]      len_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic [DATA_W-1:0]     rdata_q;
   logic [IDX_W-1:0]      idx;
   logic                  sclk_q, cs_q, sdo_q, oe_q, done_q;
   logic [IMG_W-1:0]      img;
   logic                  tick;
   logic                  accept;
   logic [DIV_W-1:0]      eff_half;
   logic [IDX_W-1:0]      last_idx;
   logic [5:0]            dpos;
   logic [5:0]            rbit;
   logic                  din;
   logic                  in_data;

   assign accept   = cmd_valid && (st == ST_IDLE);
   assign eff_half = (cfg_half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : cfg_half_div;
   assign last_idx = IDX_W'(CTRL_W + 7) + {1'b0, len_q, 3'b000};
   assign dpos     = 6'(idx - IDX_W'(CTRL_W));
   assign rbit     = {dpos[5:3], lsb_q ? dpos[2:0] : ~dpos[2:0]};
   assign din      = tw_q ? spi_sdio_i : spi_sdi;
   assign in_data  = (idx >= IDX_W'(CTRL_W));

   spi_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .run   (st != ST_IDLE),
      .half  (eff_half),
      .tick  (tick)
   );

   spi_frame_map u_map (
      .header    (make_header(wr_q, len_q, addr_q)),
      .wdata     (wdata_q),
      .lsb_first (lsb_q),
      .img       (img)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         wr_q    <= 1'b0;
         lsb_q   <= 1'b0;
         tw_q    <= 1'b0;
         len_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         idx     <= '0;
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
         sdo_q   <= 1'b0;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (cmd_valid) begin
               wr_q    <= cmd_write;
               lsb_q   <= cfg_lsb_first;
               tw_q    <= cfg_three_wire;
               len_q   <= cmd_len_m1;
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               rdata_q <= '0;
               idx     <= '0;
               cs_q    <= 1'b0;
               oe_q    <= 1'b1;
               st      <= ST_LEAD;
            end
            ST_LEAD: if (tick) begin
               sclk_q <= 1'b1;
               sdo_q  <= img[idx];
               st     <= ST_SHIFT;
            end
            ST_SHIFT: if (tick) begin
               if (sclk_q) begin
                  sclk_q <= 1'b0;
                  if (!wr_q && in_data) rdata_q[rbit] <= din;
                  if (idx == last_idx) st <= ST_TRAIL;
                  else                 idx <= idx + 1'b1;
               end else begin
                  sclk_q <= 1'b1;
                  sdo_q  <= img[idx];
                  oe_q   <= !(tw_q && !wr_q && in_data);
               end
            end
            ST_TRAIL: if (tick) begin
               cs_q   <= 1'b1;
               oe_q   <= 1'b0;
               sdo_q  <= 1'b0;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign done       = done_q;
   assign rsp_rdata  = rdata_q;
   assign spi_cs_n   = cs_q;
   assign spi_sclk   = sclk_q;
   assign spi_sdo    = sdo_q;
   assign spi_sdo_oe = oe_q;

   AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk); // R2
   AST_LEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |=> !spi_sclk); // R2
   AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |=> spi_sclk); // R5
   AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && !$rose(spi_sclk) && !$fell(spi_cs_n)) |-> $stable(spi_sdo)); // R3
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SHIFT && sclk_q && tw_q && !wr_q && in_data) |-> !spi_sdo_oe); // R7
   AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sdo_oe); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !busy)); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && !done) |=> $stable(addr_q)); // R9
endmodule

// File: tb/spi_xact_master_bench.sv
`timescale 1ns/1ps
module spi_xact_master_bench;
   localparam int HALF_NS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_write = 1'b0;
   logic [9:0]  cmd_addr = '0;
   logic [2:0]  cmd_len_m1 = '0;
   logic [63:0] cmd_wdata = '0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_three_wire = 1'b0;
   logic [7:0]  cfg_half_div = 8'd2;
   logic        busy, done, spi_cs_n, spi_sclk, spi_sdo, spi_sdo_oe;
   logic [63:0] rsp_rdata;
   logic        spi_sdi, spi_sdio_i;
   logic        slv_bit = 1'b0;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #(HALF_NS) clk = ~clk;

   spi_xact_master u_spi_xact_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_len_m1(cmd_len_m1), .cmd_wdata(cmd_wdata),
      .cfg_lsb_first(cfg_lsb_first), .cfg_three_wire(cfg_three_wire),
      .cfg_half_div(cfg_half_div), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
      .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo),
      .spi_sdo_oe(spi_sdo_oe), .spi_sdi(spi_sdi), .spi_sdio_i(spi_sdio_i)
   );

   assign spi_sdi    = slv_bit;
   assign spi_sdio_i = spi_sdo_oe ? spi_sdo : slv_bit;

   // transaction context for the far-end model
   logic [79:0] cap;
   int          fall_n, rise_n, exp_half;
   time         t_last;
   bit          tim_ok, oe_ok, in_txn = 0;
   bit          t_wr, t_lsb, t_tw;
   logic [63:0] slv_data;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_line(int i, bit wr, logic [2:0] l, logic [9:0] a, logic [63:0] wd, bit lsb);
      logic [15:0] h = {wr, l, 2'b00, a};
      int j, b, k;
      if (i < 16) return lsb ? h[i] : h[15-i];
      j = i - 16; b = j / 8; k = j % 8;
      return lsb ? wd[8*b+k] : wd[8*b+7-k];
   endfunction

   function automatic bit far_bit(int j);
      int b = j / 8;
      int k = j % 8;
      return t_lsb ? slv_data[8*b+k] : slv_data[8*b+7-k];
   endfunction

   always @(negedge spi_cs_n) begin
      in_txn = 1; fall_n = 0; rise_n = 0; t_last = $time;
   end

   always @(posedge spi_sclk) begin
      if ($time - t_last != exp_half * 2 * HALF_NS) tim_ok = 0;
      t_last = $time;
      if (rise_n >= 16) slv_bit = far_bit(rise_n - 16);
      rise_n++;
   end

   always @(negedge spi_sclk) begin
      bit exp_oe;
      if ($time - t_last != exp_half * 2 * HALF_NS) tim_ok = 0;
      t_last = $time;
      if (fall_n < 80) cap[fall_n] = spi_sdo;
      exp_oe = !(t_tw && !t_wr && fall_n >= 16);
      if (spi_sdo_oe !== exp_oe) oe_ok = 0;
      fall_n++;
   end

   always @(posedge spi_cs_n) begin
      if (in_txn && ($time - t_last != exp_half * 2 * HALF_NS)) tim_ok = 0;
   end

   task automatic run_txn(input bit wr, input logic [2:0] l, input logic [9:0] a,
                          input logic [63:0] wd, input bit lsb, input bit tw,
                          input logic [7:0] hd, input bit poke);
      int total = 16 + 8 * (int'(l) + 1);
      int miss_h = 0, miss_d = 0, cyc = 0;
      bit seen = 0;
      logic [63:0] mask, exp_rd;
      t_wr = wr; t_lsb = lsb; t_tw = tw;
      exp_half = (hd < 2) ? 2 : int'(hd);
      slv_data = {$urandom, $urandom};
      tim_ok = 1; oe_ok = 1; cap = '0;
      @(negedge clk);
      cmd_write = wr; cmd_addr = a; cmd_len_m1 = l; cmd_wdata = wd;
      cfg_lsb_first = lsb; cfg_three_wire = tw; cfg_half_div = hd; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
      chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
      if (poke) begin
         repeat (5) @(negedge clk);
         cmd_write = ~wr; cmd_addr = ~a; cmd_len_m1 = ~l; cmd_valid = 1;
         @(negedge clk);
         cmd_valid = 0;
      end
      while (!seen && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (done === 1'b1) seen = 1;
      end
      chk(seen, "R9 done pulse seen", 64'(seen), 64'd1);
      chk(spi_cs_n === 1'b1 && busy === 1'b0, "R9 idle at done", {spi_cs_n, busy}, 64'b10);
      @(negedge clk);
      chk(done === 1'b0, "R9 done one cycle", 64'(done), 64'd0);
      chk(fall_n == total, "R4 pulse count", 64'(fall_n), 64'(total));
      for (int i = 0; i < total && i < 80; i++) begin
         if (cap[i] !== exp_line(i, wr, l, a, wd, lsb)) begin
            if (i < 16) miss_h++; else miss_d++;
         end
      end
      chk(miss_h == 0, lsb ? "R8 R1 header bits" : "R1 header bits", 64'(miss_h), 64'd0);
      if (wr)
         chk(miss_d == 0, lsb ? "R8 R3 write data bits" : "R3 R4 write data bits", 64'(miss_d), 64'd0);
      chk(tim_ok, "R2 R5 edge timing", 64'(tim_ok), 64'd1);
      chk(oe_ok, "R7 drive enable", 64'(oe_ok), 64'd1);
      if (!wr) begin
         mask = (l == 3'd7) ? '1 : ((64'd1 << (8 * (int'(l) + 1))) - 64'd1);
         exp_rd = slv_data & mask;
         chk(rsp_rdata === exp_rd, lsb ? "R8 R6 read data" : "R6 R3 read data", rsp_rdata, exp_rd);
      end
      if (poke) begin
         repeat (12) @(negedge clk);
         chk(spi_cs_n === 1'b1 && busy === 1'b0, "R9 command ignored while busy",
             {spi_cs_n, busy}, 64'b10);
      end
      in_txn = 0;
   endtask

   initial begin
      #(200000 * 2 * HALF_NS);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      chk({spi_cs_n, spi_sclk, spi_sdo_oe, busy, done} === 5'b10000,
          "R2 R7 R9 reset state", {spi_cs_n, spi_sclk, spi_sdo_oe, busy, done}, 64'b10000);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // directed corners
      run_txn(1, 3'd0, 10'h2A5, 64'h00000000000000C3, 0, 0, 8'd2, 0);
      run_txn(0, 3'd7, 10'h3FF, 64'h0, 1, 1, 8'd3, 0);
      run_txn(0, 3'd0, 10'h001, 64'h0, 0, 1, 8'd0, 0);
      run_txn(1, 3'd7, 10'h155, 64'h0123456789ABCDEF, 1, 1, 8'd1, 0);
      run_txn(0, 3'd3, 10'h0F0, 64'h0, 0, 0, 8'd4, 1);
      run_txn(1, 3'd2, 10'h30C, 64'hFFEEDDCCBBAA9988, 0, 1, 8'd3, 1);
      // constrained random
      for (int n = 0; n < 30; n++) begin
         run_txn(1'($urandom), 3'($urandom), 10'($urandom), {$urandom, $urandom},
                 1'($urandom), 1'($urandom), 8'($urandom_range(0, 4)), 1'($urandom_range(0, 3) == 0));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule